// File: doc/BRIEF.md
# Converter Result Routing Arbiter

This block collects returned conversion results from four sources: two on-chip converters, an external converter link and a companion filter module. Each result is a data word with a 4-bit message tag and a small destination field. The block serves the sources by fixed priority. It decodes the tag of the served result, and then does one of three things: it writes the word into one of the result FIFOs, it passes the word to the companion-module port together with its tag and destination, or it discards the word.

The block does not hold the FIFO storage. It drives one write strobe per FIFO and one shared write-data bus, and it reads back one full flag per FIFO. Each source holds its result and its request until the block acknowledges it, and it may present the next result in the cycle after the acknowledge. A result from an on-chip converter can carry a time stamp. The result and its stamp then go into the same FIFO as two entries with nothing written between them.

Top module: `conv_result_router`

## Requirements
- R1: A result whose tag is 0 to 5 is written into the FIFO of that number. The strobe used is `fifo_wr[tag]`, and `fifo_wdata` carries the data word. When no time stamp applies, the source is acknowledged in the same cycle.
- R2: A result with tag 8 is presented on the companion port. `fwd_valid` is high, and `fwd_data`, `fwd_tag` and `fwd_dest` carry the word, the tag and the destination. No FIFO is written in that cycle.
- R3: A result with tag 15 (null), or with a reserved tag (6, 7 or 9 to 14), is acknowledged in the cycle it is presented. It causes no FIFO write and no forward.
- R4: When several sources request at once, the lowest-numbered requesting source is acknowledged. Source 0 and source 1 are the on-chip converters, source 2 is the external link and source 3 is the companion module. A source that keeps requesting is served again before any lower-priority source.
- R5: A result with the stamp flag set, from source 0 or source 1 and with a FIFO tag, is written over two write cycles. The data word goes first, then the stamp word follows into the same FIFO on the next cycle that is not stalled. The acknowledge comes with the stamp write.
- R6: The stamp flag is ignored for sources 2 and 3, and it is ignored for tags that forward or drop. Such results finish in a single cycle.
- R7: No FIFO is written while its full flag is high. The transfer waits with the source unacknowledged, and it completes once the flag drops. A full flag on a different FIFO does not stall the transfer.
- R8: While `fwd_ready` is low, the forward is held with `fwd_valid` high and the source unacknowledged. The forward completes in the first cycle in which `fwd_ready` is high.
- R9: Once a transfer has stalled or has written its first word, no other source is served until that transfer completes. This holds even for a source of higher priority.
- R10: In any cycle, at most one FIFO strobe is high and at most one source is acknowledged, and only a source that is requesting is acknowledged.
- R11: Reset ends any transfer in progress. With no request present after reset, all strobes, acknowledges and `fwd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_valid | input | NUM_SRC | Per-source result request |
| src_ack | output | NUM_SRC | Per-source completion acknowledge |
| src_data | input | NUM_SRC*DATA_W | Result word per source |
| src_tag | input | NUM_SRC*TAG_W | Message tag per source |
| src_dest | input | NUM_SRC*DEST_W | Destination field per source |
| src_stamped | input | NUM_SRC | Result carries a time stamp |
| src_stamp | input | NUM_SRC*DATA_W | Time stamp word per source |
| fifo_full | input | NUM_FIFO | Full flag per result FIFO |
| fifo_wr | output | NUM_FIFO | Write strobe per result FIFO |
| fifo_wdata | output | DATA_W | Shared FIFO write data |
| fwd_valid | output | 1 | Companion port word valid |
| fwd_ready | input | 1 | Companion port accepts word |
| fwd_data | output | DATA_W | Forwarded result word |
| fwd_tag | output | TAG_W | Forwarded tag |
| fwd_dest | output | DEST_W | Forwarded destination |

## Verification
The assertions check the following on every cycle: no write goes to a full FIFO, at most one strobe and at most one acknowledge are high, only a requesting source is acknowledged, a held forward is not acknowledged, and a forward never coincides with a FIFO write. They also check that the first half of a stamped pair is followed by a write to the same FIFO, or by no write at all. The bench scenarios show the rest: which FIFO each tag reaches, the data words it carries, the priority order across every combination of requests, the lock that holds off a source arriving during a stall, and the clearing of a stalled transfer by reset.

// File: rtl/conv_rr_pkg.sv
package conv_rr_pkg;

   typedef enum logic [1:0] {
      ROUTE_DROP = 2'd0,
      ROUTE_FIFO = 2'd1,
      ROUTE_FWD  = 2'd2
   } route_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/conv_rr_prio_pick.sv
module conv_rr_prio_pick #(
   parameter int unsigned NUM_REQ = 4,
   localparam int unsigned IDX_W = conv_rr_pkg::idx_width(NUM_REQ)
) (
   input  logic [NUM_REQ-1:0] req,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);

   logic [NUM_REQ:0]   seen;
   logic [NUM_REQ-1:0] win;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_chain
      assign win[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end

   assign any = seen[NUM_REQ];

   always_comb begin
      idx = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
         if (win[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/conv_rr_tag_decode.sv
module conv_rr_tag_decode #(
   parameter int unsigned TAG_W     = 4,
   parameter int unsigned NUM_FIFO  = 6,
   parameter int unsigned FWD_CODE  = 8,
   localparam int unsigned FIDX_W   = conv_rr_pkg::idx_width(NUM_FIFO)
) (
   input  logic [TAG_W-1:0]        tag,
   output conv_rr_pkg::route_e     route,
   output logic [FIDX_W-1:0]       fifo_idx
);
   import conv_rr_pkg::*;

   if (NUM_FIFO > FWD_CODE) begin : g_bad_code
      $error("conv_rr_tag_decode: FIFO numbers overlap the forward code");
   end

   always_comb begin
      fifo_idx = FIDX_W'(tag);
      if (32'(tag) < NUM_FIFO)       route = ROUTE_FIFO;
      else if (32'(tag) == FWD_CODE) route = ROUTE_FWD;
      else                           route = ROUTE_DROP;
   end

endmodule

// File: rtl/conv_rr_xfer_ctrl.sv
module conv_rr_xfer_ctrl #(
   parameter int unsigned NUM_SRC = 4,
   localparam int unsigned IDX_W  = conv_rr_pkg::idx_width(NUM_SRC)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pick_any,
   input  logic [IDX_W-1:0]     pick_idx,
   input  conv_rr_pkg::route_e  route,
   input  logic                 stamp_req,
   input  logic                 sel_full,
   input  logic                 fwd_ready,
   output logic [IDX_W-1:0]     cur_idx,
   output logic                 write_en,
   output logic                 write_stamp,
   output logic                 fwd_valid,
   output logic                 done
);
   import conv_rr_pkg::*;

   logic             busy_q;
   logic             phase_q;
   logic [IDX_W-1:0] grant_q;
   logic             active;

   always_comb begin
      cur_idx     = busy_q ? grant_q : pick_idx;
      active      = busy_q | pick_any;
      write_en    = 1'b0;
      write_stamp = 1'b0;
      fwd_valid   = 1'b0;
      done        = 1'b0;
      if (active) begin
         unique case (route)
            ROUTE_FIFO: begin
               if (!sel_full) begin
                  write_en    = 1'b1;
                  write_stamp = phase_q;
                  done        = phase_q | ~stamp_req;
               end
            end
            ROUTE_FWD: begin
               fwd_valid = 1'b1;
               done      = fwd_ready;
            end
            default: done = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         grant_q <= '0;
      end else if (done) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (active) begin
         busy_q  <= 1'b1;
         grant_q <= cur_idx;
         if (write_en) phase_q <= 1'b1;
      end
   end

endmodule

// File: rtl/conv_result_router.sv
module conv_result_router #(
   parameter int unsigned NUM_SRC     = 4,
   parameter int unsigned NUM_STAMPED = 2,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TAG_W       = 4,
   parameter int unsigned DEST_W      = 2,
   parameter int unsigned NUM_FIFO    = 6,
   parameter int unsigned FWD_CODE    = 8,
   localparam int unsigned IDX_W      = conv_rr_pkg::idx_width(NUM_SRC),
   localparam int unsigned FIDX_W     = conv_rr_pkg::idx_width(NUM_FIFO)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         src_valid,
   output logic [NUM_SRC-1:0]         src_ack,
   input  logic [NUM_SRC*DATA_W-1:0]  src_data,
   input  logic [NUM_SRC*TAG_W-1:0]   src_tag,
   input  logic [NUM_SRC*DEST_W-1:0]  src_dest,
   input  logic [NUM_SRC-1:0]         src_stamped,
   input  logic [NUM_SRC*DATA_W-1:0]  src_stamp,
   input  logic [NUM_FIFO-1:0]        fifo_full,
   output logic [NUM_FIFO-1:0]        fifo_wr,
   output logic [DATA_W-1:0]          fifo_wdata,
   output logic                       fwd_valid,
   input  logic                       fwd_ready,
   output logic [DATA_W-1:0]          fwd_data,
   output logic [TAG_W-1:0]           fwd_tag,
   output logic [DEST_W-1:0]          fwd_dest
);
   import conv_rr_pkg::*;

   if (NUM_SRC < 2) begin : g_bad_src
      $error("conv_result_router: at least two sources are needed");
   end
   if (NUM_STAMPED > NUM_SRC) begin : g_bad_stamp
      $error("conv_result_router: more stamping sources than sources");
   end
   if (NUM_FIFO < 1 || FWD_CODE >= (1 << TAG_W)) begin : g_bad_tag
      $error("conv_result_router: tag space does not fit the FIFO and forward codes");
   end

   logic [DATA_W-1:0] data_a  [NUM_SRC];
   logic [DATA_W-1:0] stamp_a [NUM_SRC];
   logic [TAG_W-1:0]  tag_a   [NUM_SRC];
   logic [DEST_W-1:0] dest_a  [NUM_SRC];
   logic [NUM_SRC-1:0] stamp_cap;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_unpack
      assign data_a[s]  = src_data[s*DATA_W +: DATA_W];
      assign stamp_a[s] = src_stamp[s*DATA_W +: DATA_W];
      assign tag_a[s]   = src_tag[s*TAG_W +: TAG_W];
      assign dest_a[s]  = src_dest[s*DEST_W +: DEST_W];
      if (s < NUM_STAMPED) begin : g_cap
         assign stamp_cap[s] = src_stamped[s];
      end else begin : g_nocap
         assign stamp_cap[s] = 1'b0;
      end
   end

   logic              pick_any;
   logic [IDX_W-1:0]  pick_idx;
   logic [IDX_W-1:0]  cur_idx;
   route_e            route;
   logic [FIDX_W-1:0] fifo_idx;
   logic              sel_full;
   logic              write_en;
   logic              write_stamp;
   logic              done;
   logic              fwd_go;

   conv_rr_prio_pick #(.NUM_REQ(NUM_SRC)) u_pick (
      .req (src_valid),
      .any (pick_any),
      .idx (pick_idx)
   );

   conv_rr_tag_decode #(
      .TAG_W    (TAG_W),
      .NUM_FIFO (NUM_FIFO),
      .FWD_CODE (FWD_CODE)
   ) u_decode (
      .tag      (tag_a[cur_idx]),
      .route    (route),
      .fifo_idx (fifo_idx)
   );

   assign sel_full = (route == ROUTE_FIFO) ? fifo_full[fifo_idx] : 1'b0;

   conv_rr_xfer_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .pick_any    (pick_any),
      .pick_idx    (pick_idx),
      .route       (route),
      .stamp_req   (stamp_cap[cur_idx]),
      .sel_full    (sel_full),
      .fwd_ready   (fwd_ready),
      .cur_idx     (cur_idx),
      .write_en    (write_en),
      .write_stamp (write_stamp),
      .fwd_valid   (fwd_go),
      .done        (done)
   );

   always_comb begin
      src_ack = '0;
      if (done) src_ack[cur_idx] = 1'b1;
      fifo_wr = '0;
      if (write_en) fifo_wr[fifo_idx] = 1'b1;
   end

   assign fifo_wdata = write_stamp ? stamp_a[cur_idx] : data_a[cur_idx];
   assign fwd_valid  = fwd_go;
   assign fwd_data   = fwd_go ? data_a[cur_idx] : '0;
   assign fwd_tag    = fwd_go ? tag_a[cur_idx]  : '0;
   assign fwd_dest   = fwd_go ? dest_a[cur_idx] : '0;

endmodule

// File: rtl/conv_result_router_chk.sv
module conv_result_router_chk #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned NUM_FIFO = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_SRC-1:0]  src_valid,
   input logic [NUM_SRC-1:0]  src_ack,
   input logic [NUM_FIFO-1:0] fifo_full,
   input logic [NUM_FIFO-1:0] fifo_wr,
   input logic                fwd_valid,
   input logic                fwd_ready
);

   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr & fifo_full) == '0);                                         // R7

   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_wr));                                                   // R10

   AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_ack));                                                   // R10

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ack & ~src_valid) == '0);                                        // R10

   AST_FWD_NO_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fifo_wr == '0));                                       // R2

   AST_FWD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_ready) |-> (src_ack == '0));                       // R8

   AST_STAMP_SAME_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_wr != '0 && src_ack == '0) |=>
         (fifo_wr == '0 || fifo_wr == $past(fifo_wr)));                     // R5

endmodule

bind conv_result_router conv_result_router_chk #(
   .NUM_SRC  (NUM_SRC),
   .NUM_FIFO (NUM_FIFO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_ack   (src_ack),
   .fifo_full (fifo_full),
   .fifo_wr   (fifo_wr),
   .fwd_valid (fwd_valid),
   .fwd_ready (fwd_ready)
);

// File: tb/conv_result_router_test.sv
module conv_result_router_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_valid = '0;
   logic [3:0]  src_ack;
   logic [63:0] src_data = '0;
   logic [15:0] src_tag = '0;
   logic [7:0]  src_dest = '0;
   logic [3:0]  src_stamped = '0;
   logic [63:0] src_stamp = '0;
   logic [5:0]  fifo_full = '0;
   logic [5:0]  fifo_wr;
   logic [15:0] fifo_wdata;
   logic        fwd_valid;
   logic        fwd_ready = 1'b1;
   logic [15:0] fwd_data;
   logic [3:0]  fwd_tag;
   logic [1:0]  fwd_dest;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   conv_result_router uut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ack(src_ack),
      .src_data(src_data), .src_tag(src_tag), .src_dest(src_dest),
      .src_stamped(src_stamped), .src_stamp(src_stamp), .fifo_full(fifo_full),
      .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fwd_valid(fwd_valid),
      .fwd_ready(fwd_ready), .fwd_data(fwd_data), .fwd_tag(fwd_tag),
      .fwd_dest(fwd_dest)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic put(input int s, input logic [3:0] tag, input logic [1:0] dest,
                      input logic [15:0] data, input logic ts, input logic [15:0] stamp);
      src_valid[s]          = 1'b1;
      src_tag[s*4 +: 4]     = tag;
      src_dest[s*2 +: 2]    = dest;
      src_data[s*16 +: 16]  = data;
      src_stamped[s]        = ts;
      src_stamp[s*16 +: 16] = stamp;
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   task automatic look;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step(); look();
      chk("R11", "ack idle", 32'(src_ack), 0);
      chk("R11", "wr idle", 32'(fifo_wr), 0);
      chk("R11", "fwd idle", 32'(fwd_valid), 0);

      // R1 R2 R3: every tag on every source
      for (int s = 0; s < 4; s++) begin
         for (int t = 0; t < 16; t++) begin
            step();
            src_valid = '0;
            put(s, 4'(t), 2'(t % 4), 16'hA000 | 16'(s << 8) | 16'(t), 1'b0, 16'h0);
            look();
            chk(t < 6 ? "R1" : (t == 8 ? "R2" : "R3"), "ack",
                32'(src_ack), 32'(1 << s));
            chk(t < 6 ? "R1" : "R3", "wr", 32'(fifo_wr), t < 6 ? 32'(1 << t) : 0);
            chk("R2", "fwd_valid", 32'(fwd_valid), (t == 8) ? 1 : 0);
            if (t < 6)
               chk("R1", "wdata", 32'(fifo_wdata), 32'(16'hA000 | 16'(s << 8) | 16'(t)));
            if (t == 8) begin
               chk("R2", "fwd_data", 32'(fwd_data), 32'(16'hA000 | 16'(s << 8) | 16'(t)));
               chk("R2", "fwd_tag", 32'(fwd_tag), 8);
               chk("R2", "fwd_dest", 32'(fwd_dest), 0);
            end
         end
      end
      step(); src_valid = '0;

      // R4: all request combinations, each source drops after its ack
      for (int m = 1; m < 16; m++) begin
         logic [3:0] pend;
         pend = 4'(m);
         for (int s = 0; s < 4; s++) put(s, 4'(s), 2'd0, 16'(16'h4400 + s), 1'b0, 16'h0);
         src_valid = pend;
         while (pend != 0) begin
            int low;
            low = 0;
            for (int k = 3; k >= 0; k--) if (pend[k]) low = k;
            look();
            chk("R4", "ack", 32'(src_ack), 32'(1 << low));
            chk("R4", "wr", 32'(fifo_wr), 32'(1 << low));
            pend[low] = 1'b0;
            step();
            src_valid = pend;
         end
      end

      // R5: stamped pair from each on-chip source; R6: stamp ignored elsewhere
      for (int s = 0; s < 4; s++) begin
         step();
         put(s, 4'd3, 2'd0, 16'(16'h1100 + s), 1'b1, 16'(16'h5500 + s));
         look();
         chk(s < 2 ? "R5" : "R6", "first wr", 32'(fifo_wr), 32'h8);
         chk(s < 2 ? "R5" : "R6", "first data", 32'(fifo_wdata), 32'(16'h1100 + s));
         chk(s < 2 ? "R5" : "R6", "first ack", 32'(src_ack), s < 2 ? 0 : 32'(1 << s));
         if (s < 2) begin
            step(); look();
            chk("R5", "stamp wr", 32'(fifo_wr), 32'h8);
            chk("R5", "stamp data", 32'(fifo_wdata), 32'(16'h5500 + s));
            chk("R5", "stamp ack", 32'(src_ack), 32'(1 << s));
         end
         step(); src_valid = '0;
      end
      step();
      put(0, 4'd8, 2'd1, 16'h7777, 1'b1, 16'h9999);
      look();
      chk("R6", "fwd stamped ack", 32'(src_ack), 1);
      step(); src_valid = '0;

      // R5 R7: stall between result and stamp
      step();
      put(0, 4'd4, 2'd0, 16'h0A0A, 1'b1, 16'h0B0B);
      look();
      chk("R5", "pair data", 32'(fifo_wdata), 32'h0A0A);
      step(); fifo_full[4] = 1'b1; put(1, 4'd0, 2'd0, 16'h1234, 1'b0, 16'h0); look();
      chk("R7", "stalled wr", 32'(fifo_wr), 0);
      chk("R9", "stalled ack", 32'(src_ack), 0);
      step(); fifo_full[4] = 1'b0; look();
      chk("R5", "stamp after stall", 32'(fifo_wdata), 32'h0B0B);
      chk("R5", "stamp ack", 32'(src_ack), 1);
      step(); src_valid[0] = 1'b0; look();
      chk("R9", "next source", 32'(src_ack), 2);
      step(); src_valid = '0;

      // R7 R9: full stall locks out higher priority
      step();
      fifo_full = 6'b100100;
      put(1, 4'd2, 2'd0, 16'hBEEF, 1'b0, 16'h0);
      look();
      chk("R7", "full no wr", 32'(fifo_wr), 0);
      chk("R7", "full no ack", 32'(src_ack), 0);
      step(); put(0, 4'd0, 2'd0, 16'hCAFE, 1'b0, 16'h0); look();
      chk("R9", "locked ack", 32'(src_ack), 0);
      chk("R9", "locked wr", 32'(fifo_wr), 0);
      step(); fifo_full = 6'b100000; look();
      chk("R7", "release wr", 32'(fifo_wr), 32'h4);
      chk("R7", "release data", 32'(fifo_wdata), 32'hBEEF);
      chk("R7", "release ack", 32'(src_ack), 2);
      step(); src_valid[1] = 1'b0; look();
      chk("R7", "other full ignored", 32'(fifo_wr), 1);
      chk("R4", "waiting source", 32'(src_ack), 1);
      step(); src_valid = '0; fifo_full = '0;

      // R8 R9: forward held by ready
      step();
      fwd_ready = 1'b0;
      put(3, 4'd8, 2'd2, 16'hD00D, 1'b0, 16'h0);
      look();
      chk("R8", "held valid", 32'(fwd_valid), 1);
      chk("R8", "held ack", 32'(src_ack), 0);
      chk("R2", "held dest", 32'(fwd_dest), 2);
      step(); put(0, 4'd1, 2'd0, 16'h0001, 1'b0, 16'h0); look();
      chk("R9", "fwd lock ack", 32'(src_ack), 0);
      chk("R9", "fwd lock wr", 32'(fifo_wr), 0);
      chk("R8", "held data", 32'(fwd_data), 32'hD00D);
      step(); fwd_ready = 1'b1; look();
      chk("R8", "ready ack", 32'(src_ack), 8);
      step(); src_valid[3] = 1'b0; look();
      chk("R4", "after fwd", 32'(src_ack), 1);
      step(); src_valid = '0;

      // R11: reset clears a stalled transfer
      step();
      fifo_full[2] = 1'b1;
      put(1, 4'd2, 2'd0, 16'h2222, 1'b0, 16'h0);
      step();
      rst_n = 1'b0;
      src_valid = '0;
      fifo_full = '0;
      step();
      rst_n = 1'b1;
      step(); look();
      chk("R11", "post reset ack", 32'(src_ack), 0);
      chk("R11", "post reset wr", 32'(fifo_wr), 0);
      put(2, 4'd5, 2'd0, 16'h3333, 1'b0, 16'h0);
      look();
      chk("R11", "fresh grant", 32'(src_ack), 4);
      chk("R11", "fresh wr", 32'(fifo_wr), 32'h20);
      step(); src_valid = '0;

      step();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule